// File: doc/BRIEF.md
# Two-Layer Stub Coincidence Finder

This block serves a tracking module that has two sensor layers stacked a short distance apart: a pixel layer whose chip is organised as columns of short pixels, and a strip layer whose strips face those columns. For each bunch crossing it takes one hit bitmap from each layer. It clears hit groups that are too wide to come from a single stiff track. It then collapses each pixel column into one virtual strip. A column that lines up with a strip hit inside a programmable window produces a stub. The window is set by a signed offset and a half-width. Its size is the transverse-momentum cut, because a soft track bends enough between the layers to fall outside it.

Each stub leaves the block as a 12-bit word on a valid/ready stream. The word holds the column number and the lowest hit pixel row of that column, which gives the position along the beam. After the stubs of a crossing comes one marker word that carries the stub count, together with the crossing's 8-bit timestamp. The block accepts a new crossing only after the marker of the previous one has been taken. A small write port sets the window offset and half-width.

Top module: `stub_finder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, the window offset is 0 and the half-width is 1.
- R2: A hit that belongs to a run of three or more adjacent active positions is removed before matching, and runs of one or two are kept. On the strip layer, adjacency is along the strip index. On the pixel layer, it is along the column index within one pixel row, so a run in one row does not clear pixels of other rows.
- R3: A column's virtual strip is the OR of its cleaned pixels. The column yields a stub when a cleaned strip hit has an index in [c+offset-halfwidth, c+offset+halfwidth].
- R4: Window positions below 0 or at or above the strip count are treated as empty and never match.
- R5: A stub word carries the column in bits [11:4] and, in bits [3:0], the lowest row index among the cleaned pixels of that column. The column is below NCOL and the row is below NROW.
- R6: Stubs of one crossing leave one per handshake in ascending column order. While `out_valid` is high and `out_ready` is low, the word and `out_last` hold steady.
- R7: Every accepted crossing ends with exactly one marker beat. On it, `out_last` is 1, `out_data[7:0]` is the stub count of that crossing and `out_ts` is its timestamp. A crossing with no stubs gives the marker alone, with count 0.
- R8: A write with `cfg_sel`=0 loads the offset from the low OFF_W bits of `cfg_wdata` as a two's-complement value. A write with `cfg_sel`=1 loads the half-width from the low HW_W bits. A crossing uses the values in force when it is accepted.
- R9: `in_ready` is 1 only while no crossing is being emitted. A crossing offered while `in_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the window offset, 1 the half-width |
| cfg_wdata | input | 8 | Configuration write value |
| in_valid | input | 1 | A crossing is offered |
| in_ready | output | 1 | The block can take a crossing |
| pix_hits | input | NCOL*NROW | Pixel bitmap, bit c*NROW+r is column c, row r |
| strip_hits | input | NSTRIP | Strip-layer bitmap |
| in_ts | input | 8 | Crossing timestamp |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_last | output | 1 | 1 on the end-of-crossing marker |
| out_data | output | 12 | Stub word, or the stub count on the marker |
| out_ts | output | 8 | Timestamp of the crossing being emitted |

## Verification
The bench builds the block with 16 columns of 4 rows and 16 strips, and keeps the 4-bit offset and 3-bit half-width. With these sizes every hit pattern is written out by hand. Windows that run off both ends of the strip array can be placed with a few writes. A crossing in which every column matches fills the stream completely. Stall patterns on `out_ready` test the holding of words, and an offer made while the block is busy tests the input gating.

// File: rtl/stub_pkg.sv
package stub_pkg;

    localparam int POS_W  = 8;
    localparam int Z_W    = 4;
    localparam int STUB_W = POS_W + Z_W;
    localparam int TS_W   = 8;
    localparam int ZSPAN  = 1 << Z_W;

    typedef struct packed {
        logic [POS_W-1:0] col;
        logic [Z_W-1:0]   z;
    } stub_word_t;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;

    localparam logic CFG_OFFSET = 1'b0;
    localparam logic CFG_HWIDTH = 1'b1;

    // index of the lowest set bit, 0 when none is set
    function automatic logic [Z_W-1:0] lowest_row(input logic [ZSPAN-1:0] bits);
        logic [Z_W-1:0] r;
        r = '0;
        for (int i = ZSPAN - 1; i >= 0; i--) begin
            if (bits[i]) r = i[Z_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/stub_cleanup.sv
module stub_cleanup #(
    parameter int W = 128
) (
    input  logic [W-1:0] hits,
    output logic [W-1:0] kept
);
    localparam int PW = W + 4;

    logic [PW-1:0] pad;
    assign pad = {2'b00, hits, 2'b00};

    // pad[i+2] is hits[i]; a hit survives only inside a run of at most two
    for (genvar i = 0; i < W; i++) begin : g_pos
        logic both_sides, two_left, two_right;
        assign both_sides = pad[i+1] & pad[i+3];
        assign two_left   = pad[i]   & pad[i+1];
        assign two_right  = pad[i+3] & pad[i+4];
        assign kept[i]    = hits[i] & ~both_sides & ~two_left & ~two_right;
    end

endmodule

// File: rtl/stub_window_match.sv
module stub_window_match #(
    parameter int NCOL   = 128,
    parameter int NSTRIP = 128,
    parameter int OFF_W  = 4,
    parameter int HW_W   = 3
) (
    input  logic [NCOL-1:0]   vstrip,
    input  logic [NSTRIP-1:0] strips,
    input  logic [OFF_W-1:0]  offset,
    input  logic [HW_W-1:0]   hwidth,
    output logic [NCOL-1:0]   matched
);
    localparam int MAXHW = (1 << HW_W) - 1;
    localparam int SIW   = (NSTRIP > 1) ? $clog2(NSTRIP) : 1;

    int offs;
    int hwi;
    assign offs = int'($signed(offset));
    assign hwi  = int'(hwidth);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        always_comb begin
            int idx;
            logic hit;
            hit = 1'b0;
            for (int d = -MAXHW; d <= MAXHW; d++) begin
                idx = c + offs + d;
                if (d >= -hwi && d <= hwi && idx >= 0 && idx < NSTRIP) begin
                    if (strips[idx[SIW-1:0]]) hit = 1'b1;
                end
            end
            matched[c] = vstrip[c] & hit;
        end
    end

endmodule

// File: rtl/stub_serializer.sv
module stub_serializer
    import stub_pkg::*;
#(
    parameter int NCOL = 128
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [NCOL-1:0]            matched,
    input  logic [NCOL-1:0][Z_W-1:0]   zcode,
    input  logic [TS_W-1:0]            ts,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic                       out_last,
    output logic [STUB_W-1:0]          out_data,
    output logic [TS_W-1:0]            out_ts
);
    localparam int COL_W = (NCOL > 1) ? $clog2(NCOL) : 1;
    localparam int CNT_W = $clog2(NCOL + 1);

    ser_state_e                 state;
    logic [NCOL-1:0]            pend;
    logic [NCOL-1:0][Z_W-1:0]   zq;
    logic [TS_W-1:0]            tsq;
    logic [CNT_W-1:0]           sent;
    logic [COL_W-1:0]           first;
    logic                       any;
    stub_word_t                 word;

    always_comb begin
        first = '0;
        for (int c = NCOL - 1; c >= 0; c--) begin
            if (pend[c]) first = c[COL_W-1:0];
        end
    end

    assign any       = |pend;
    assign in_ready  = (state == SER_IDLE);
    assign out_valid = (state == SER_SEND);
    assign out_last  = (state == SER_SEND) && !any;
    assign out_ts    = tsq;

    always_comb begin
        word.col = POS_W'(first);
        word.z   = zq[first];
        out_data = any ? STUB_W'(word) : STUB_W'(sent);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            pend  <= '0;
            zq    <= '0;
            tsq   <= '0;
            sent  <= '0;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (in_valid) begin
                        pend  <= matched;
                        zq    <= zcode;
                        tsq   <= ts;
                        sent  <= '0;
                        state <= SER_SEND;
                    end
                end
                SER_SEND: begin
                    if (out_ready) begin
                        if (any) begin
                            pend[first] <= 1'b0;
                            sent        <= sent + 1'b1;
                        end else begin
                            state <= SER_IDLE;
                        end
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stub_finder.sv
module stub_finder
    import stub_pkg::*;
#(
    parameter int NCOL   = 128,
    parameter int NROW   = 16,
    parameter int NSTRIP = 128,
    parameter int OFF_W  = 4,
    parameter int HW_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic                    cfg_sel,
    input  logic [7:0]              cfg_wdata,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [NCOL*NROW-1:0]    pix_hits,
    input  logic [NSTRIP-1:0]       strip_hits,
    input  logic [TS_W-1:0]         in_ts,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_last,
    output logic [STUB_W-1:0]       out_data,
    output logic [TS_W-1:0]         out_ts
);
    logic [OFF_W-1:0] win_off;
    logic [HW_W-1:0]  win_hw;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_off <= '0;
            win_hw  <= HW_W'(1);
        end else if (cfg_wr) begin
            if (cfg_sel == CFG_OFFSET) win_off <= cfg_wdata[OFF_W-1:0];
            else                       win_hw  <= cfg_wdata[HW_W-1:0];
        end
    end

    // pixel cleanup runs per row across columns
    logic [NROW-1:0][NCOL-1:0] row_raw, row_clean;

    for (genvar r = 0; r < NROW; r++) begin : g_row
        for (genvar c = 0; c < NCOL; c++) begin : g_bit
            assign row_raw[r][c] = pix_hits[c*NROW + r];
        end
        stub_cleanup #(.W(NCOL)) u_pix_clean (
            .hits (row_raw[r]),
            .kept (row_clean[r])
        );
    end

    logic [NSTRIP-1:0] strip_clean;

    stub_cleanup #(.W(NSTRIP)) u_strip_clean (
        .hits (strip_hits),
        .kept (strip_clean)
    );

    logic [NCOL-1:0][NROW-1:0] col_bits;
    logic [NCOL-1:0]           vstrip;
    logic [NCOL-1:0][Z_W-1:0]  zcode;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar r = 0; r < NROW; r++) begin : g_row
            assign col_bits[c][r] = row_clean[r][c];
        end
        assign vstrip[c] = |col_bits[c];
        assign zcode[c]  = lowest_row(ZSPAN'(col_bits[c]));
    end

    logic [NCOL-1:0] matched;

    stub_window_match #(
        .NCOL   (NCOL),
        .NSTRIP (NSTRIP),
        .OFF_W  (OFF_W),
        .HW_W   (HW_W)
    ) u_match (
        .vstrip  (vstrip),
        .strips  (strip_clean),
        .offset  (win_off),
        .hwidth  (win_hw),
        .matched (matched)
    );

    stub_serializer #(.NCOL(NCOL)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .matched   (matched),
        .zcode     (zcode),
        .ts        (in_ts),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .out_data  (out_data),
        .out_ts    (out_ts)
    );

endmodule

// File: rtl/stub_finder_chk.sv
module stub_finder_chk #(
    parameter int NCOL = 128,
    parameter int NROW = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_last,
    input logic [11:0] out_data
);
    logic [8:0] seen;
    logic [7:0] prev_col;
    logic       have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen      <= '0;
            prev_col  <= '0;
            have_prev <= 1'b0;
        end else if (out_valid && out_ready) begin
            if (out_last) begin
                seen      <= '0;
                have_prev <= 1'b0;
            end else begin
                seen      <= seen + 1'b1;
                prev_col  <= out_data[11:4];
                have_prev <= 1'b1;
            end
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R6

    AST_ASCENDING_COL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last && have_prev |-> out_data[11:4] > prev_col); // R6

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R9

    AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R7

    AST_MARKER_COUNT: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> out_data == 12'(seen)); // R7

    AST_STUB_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |-> (int'(out_data[11:4]) < NCOL) && (int'(out_data[3:0]) < NROW)); // R5

endmodule

bind stub_finder stub_finder_chk #(.NCOL(NCOL), .NROW(NROW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_data  (out_data)
);

// File: tb/tb_stub_finder.sv
`timescale 1ns/1ps
module tb_stub_finder;
    localparam int NC = 16;
    localparam int NR = 4;
    localparam int NS = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_wr = 1'b0;
    logic           cfg_sel = 1'b0;
    logic [7:0]     cfg_wdata = '0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [NC*NR-1:0] pix = '0;
    logic [NS-1:0]  strips = '0;
    logic [7:0]     in_ts = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic           out_last;
    logic [11:0]    out_data;
    logic [7:0]     out_ts;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int got_col [0:31];
    int got_z   [0:31];
    int got_n;
    int mark_cnt;
    int mark_ts;

    always #2.5 clk = ~clk;

    stub_finder #(.NCOL(NC), .NROW(NR), .NSTRIP(NS), .OFF_W(4), .HW_W(3)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .pix_hits(pix), .strip_hits(strips),
        .in_ts(in_ts), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .out_data(out_data), .out_ts(out_ts)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void setpix(int c, int r);
        pix[c*NR + r] = 1'b1;
    endfunction

    task automatic cfg_write(input logic sel, input logic [7:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] ts);
        @(negedge clk);
        in_ts = ts;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // mode 0: always ready, 1: every other cycle, 2: every third cycle
    task automatic collect(input int mode);
        got_n = 0; mark_cnt = -1; mark_ts = -1;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (cyc > 0) @(negedge clk);
            out_ready = (mode == 0) || (mode == 1 && cyc % 2 == 1) || (mode == 2 && cyc % 3 == 2);
            if (out_valid && out_ready) begin
                if (out_last) begin
                    mark_cnt = int'(out_data[7:0]);
                    mark_ts  = int'(out_ts);
                    break;
                end
                if (got_n < 32) begin
                    got_col[got_n] = int'(out_data[11:4]);
                    got_z[got_n]   = int'(out_data[3:0]);
                end
                got_n++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    endtask

    task automatic t_basic();
        pix = '0; strips = '0;
        setpix(3, 2); strips[4] = 1'b1;
        setpix(8, 1); setpix(8, 3); strips[8] = 1'b1;
        setpix(12, 0); strips[14] = 1'b1;
        send(8'h5A);
        collect(1);
        chk(got_n == 2, "R3 stub count", got_n, 2);
        chk(got_col[0] == 3 && got_z[0] == 2, "R5 first stub col*16+z", got_col[0]*16+got_z[0], 3*16+2);
        chk(got_col[1] == 8 && got_z[1] == 1, "R5 lowest row", got_col[1]*16+got_z[1], 8*16+1);
        chk(mark_cnt == 2, "R7 marker count", mark_cnt, 2);
        chk(mark_ts == 8'h5A, "R7 marker ts", mark_ts, 8'h5A);
    endtask

    task automatic t_cleanup();
        pix = '0; strips = '0;
        setpix(1, 0); setpix(2, 0); setpix(3, 0);
        setpix(2, 2);
        strips[2] = 1'b1;
        setpix(6, 1); setpix(7, 1); strips[6] = 1'b1;
        setpix(11, 3); strips[10] = 1'b1; strips[11] = 1'b1; strips[12] = 1'b1;
        send(8'h11);
        collect(2);
        chk(got_n == 3, "R2 surviving stubs", got_n, 3);
        chk(got_col[0] == 2 && got_z[0] == 2, "R2 other row kept", got_col[0]*16+got_z[0], 2*16+2);
        chk(got_col[1] == 6 && got_col[2] == 7, "R2 pair kept", got_col[1]*16+got_col[2], 6*16+7);
        chk(mark_cnt == 3, "R7 count after cleanup", mark_cnt, 3);
    endtask

    task automatic t_config();
        cfg_write(1'b0, 8'h02);
        cfg_write(1'b1, 8'h00);
        pix = '0; strips = '0;
        setpix(5, 0); strips[7] = 1'b1;
        setpix(9, 1); strips[10] = 1'b1;
        setpix(15, 2); strips[15] = 1'b1;
        send(8'h22);
        collect(0);
        chk(got_n == 1 && got_col[0] == 5, "R8 offset +2 width 0", got_n*100+got_col[0], 105);
        chk(mark_cnt == 1, "R4 upper edge empty", mark_cnt, 1);
        cfg_write(1'b0, 8'h0D);
        cfg_write(1'b1, 8'h02);
        pix = '0; strips = '0;
        setpix(0, 0); setpix(4, 3); strips[0] = 1'b1;
        send(8'h33);
        collect(0);
        chk(got_n == 1 && got_col[0] == 4 && got_z[0] == 3, "R4 lower edge, R8 offset -3",
            got_n*100+got_col[0]*16+got_z[0], 100+4*16+3);
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h01);
    endtask

    task automatic t_empty();
        pix = '0; strips = '0;
        send(8'hC3);
        collect(0);
        chk(got_n == 0, "R7 empty no stubs", got_n, 0);
        chk(mark_cnt == 0 && mark_ts == 8'hC3, "R7 empty marker", mark_cnt*256+mark_ts, 8'hC3);
    endtask

    task automatic t_full();
        pix = '0; strips = '0;
        for (int c = 0; c < NC; c++) setpix(c, c % 2);
        for (int s = 0; s < NS; s += 3) strips[s] = 1'b1;
        send(8'h7E);
        collect(1);
        chk(got_n == 16, "R6 all columns", got_n, 16);
        for (int i = 0; i < 16; i++) begin
            chk(got_col[i] == i && got_z[i] == i % 2, "R6 order", got_col[i]*16+got_z[i], i*16+i%2);
        end
        chk(mark_cnt == 16, "R7 full count", mark_cnt, 16);
    endtask

    task automatic t_busy();
        pix = '0; strips = '0;
        setpix(1, 0); strips[1] = 1'b1;
        send(8'h44);
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 busy", int'(in_ready), 0);
        pix = '0; strips = '0;
        setpix(10, 1); strips[10] = 1'b1;
        in_ts = 8'h99;
        in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        collect(0);
        chk(got_n == 1 && got_col[0] == 1, "R9 offer ignored", got_n*100+got_col[0], 101);
        chk(mark_ts == 8'h44, "R9 ts kept", mark_ts, 8'h44);
        chk(in_ready == 1'b1, "R9 idle again", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R9 nothing pending", int'(out_valid), 0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_cleanup();
        t_config();
        t_empty();
        t_full();
        t_busy();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule